// File: doc/BRIEF.md
# Multiprocessor Wake Serial Transmitter

This block is a buffered asynchronous serial transmitter for a bus shared by several receivers. A one-entry holding register accepts bytes over a valid/ready stream port. A shift engine sends each byte as a character on a single line. The engine advances one bit per pulse of an external baud enable. The holding register and the shift engine overlap, so the host can queue the next byte while the current character is still on the line.

Receivers on the bus can tell address characters from data characters in two ways, chosen by a mode pin. In address-bit mode, each character carries one extra flag bit just before its stop bit. In idle-line mode, a character is an address when the line has been quiet for more than ten bit times before it.

To make such a quiet gap, the host sets a wake request and then pushes a throw-away byte. When that byte reaches the shift engine it is discarded, and the line is held at mark for eleven bit periods. The wake request is cleared, and an optional interrupt is raised, on the same clock edge on which the holding register empties. The line is driven by this block alone; there is no arbitration.

Top module: `wake_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `s_ready` is 1, `wake_pend` is 0, `irq` is 0 and `tx_empty` is 1.
- R2: A byte is accepted on a rising clock edge where `s_valid` and `s_ready` are both 1. `s_ready` then stays 0 until that byte moves to the shift engine. While `s_ready` is 0, no further byte is taken and the held byte is not altered. The stream rule is that a source holding `s_valid` high keeps its data steady until the byte is accepted.
- R3: With `mode_abit` = 0, a character is 10 bit periods long: a start bit of 0, then the 8 data bits least significant first, then a stop bit of 1. Each bit lasts from one baud pulse to the next.
- R4: With `mode_abit` = 1, an extra bit equal to the `s_addr_flag` value captured with the byte is sent between data bit 7 and the stop bit, so a character is 11 bit periods long.
- R5: If a byte is waiting in the holding register when a stop bit ends, the next start bit begins on that same baud pulse, with no idle bit between the two characters.
- R6: A byte moves from the holding register to the shift engine, and `s_ready` rises, only on an edge where `baud_tick` is 1 and the engine is idle or is finishing its last bit.
- R7: If `wake_pend` is 1 when a byte moves to the shift engine, that byte is never sent. Instead `txd` stays at 1 for exactly 11 bit periods, and a byte already queued starts on the pulse that ends the gap.
- R8: `wake_pend` is set by a one-cycle `wake_set` pulse. It is cleared on the same edge on which `s_ready` rises, that is, when the holding register empties.
- R9: When `irq_en` is 1, `irq` is a one-cycle pulse that is high in exactly the cycle after each move to the shift engine. When `irq_en` is 0, `irq` stays 0.
- R10: `tx_empty` is 1 exactly when the holding register is empty and the shift engine is neither sending a character nor holding a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| mode_abit | input | 1 | 1 = address-bit mode, 0 = idle-line mode |
| irq_en | input | 1 | Enables the transfer interrupt |
| wake_set | input | 1 | Pulse that sets the wake request |
| s_valid | input | 1 | Byte offered on the stream port |
| s_ready | output | 1 | Holding register empty; doubles as the ready flag |
| s_data | input | 8 | Byte to send |
| s_addr_flag | input | 1 | Value of the address bit in address-bit mode |
| wake_pend | output | 1 | Wake request outstanding |
| tx_empty | output | 1 | Holding register and shift engine both idle |
| irq | output | 1 | Transfer interrupt pulse |
| txd | output | 1 | Serial line, idle high |

## Verification
The bench decodes the line one bit per baud pulse and targets the following corner cases.

- **Chained characters:** the stop bit must run straight into the next start bit. A design that waited for a fresh pulse after going idle would insert one idle bit, and the bench would see a nonzero gap.
- **Throw-away byte after a wake request:** this byte must never appear on the line. A design that shifted it out would produce an unexpected character. A design with a counter off by one would give a gap of 10 or 12 bits instead of 11.
- **Timing of wake clear and interrupt:** both must line up with the rise of `s_ready`, and that rise must follow a baud pulse. A design that cleared the wake bit at write time, or pulsed the interrupt a cycle late, shows a mismatch at that edge.
- **Address-bit mode and back-pressure:** address-bit mode is run with random flag values. A source that holds valid while the holding register is full checks that no byte is lost or duplicated.

// File: rtl/wut_pkg.sv
package wut_pkg;
  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_FRAME = 2'd1,
    SH_GAP   = 2'd2
  } sh_state_e;
endpackage

// File: rtl/wut_hold.sv
module wut_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_addr_flag,
  input  logic              xfer,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_addr
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              addr_q;

  assign s_ready   = !full_q;
  assign hold_full = full_q;
  assign hold_data = data_q;
  assign hold_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      addr_q <= 1'b0;
    end else begin
      if (s_valid && !full_q) begin
        full_q <= 1'b1;
        data_q <= s_data;
        addr_q <= s_addr_flag;
      end else if (xfer) begin
        full_q <= 1'b0;
      end
    end
  end

  // R2: an accepted byte blocks the port until it is moved on
  a_r2_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);
  // R2: a held byte is left untouched while it waits
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ready && !xfer) |=> ($stable(hold_data) && $stable(hold_addr)));
endmodule

// File: rtl/wut_wake_ctl.sv
module wut_wake_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_set,
  input  logic irq_en,
  input  logic xfer,
  output logic wake_pend,
  output logic irq
);
  logic wake_q;
  logic irq_q;

  assign wake_pend = wake_q;
  assign irq       = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      wake_q <= (wake_q && !xfer) || wake_set;
      irq_q  <= xfer && irq_en;
    end
  end

  // R8: the transfer edge consumes the wake request
  a_r8_clear_on_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !wake_set) |=> !wake_pend);
  // R8: the request only rises through the set pulse
  a_r8_set_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_pend) |-> $past(wake_set));
  // R9: an interrupt traces back to an enabled transfer
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(xfer && irq_en));
  // R9: the interrupt is a single-cycle pulse
  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: rtl/wut_shifter.sv
module wut_shifter
  import wut_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int GAP_BITS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              mode_abit,
  input  logic              load_req,
  input  logic              load_gap,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_addr,
  output logic              xfer,
  output logic              busy,
  output logic              txd
);
  localparam int SH_W   = DATA_W + 2;
  localparam int LEN_NA = DATA_W + 2;
  localparam int LEN_AB = DATA_W + 3;
  localparam int MAXC   = (GAP_BITS > LEN_AB) ? GAP_BITS : LEN_AB;
  localparam int CNT_W  = $clog2(MAXC + 1);

  sh_state_e         state_q;
  logic [SH_W-1:0]   sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              txd_q;
  logic              slot;

  assign slot = baud_tick && ((state_q == SH_IDLE) || (cnt_q == CNT_W'(1)));
  assign xfer = load_req && slot;
  assign busy = (state_q != SH_IDLE);
  assign txd  = txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      sh_q    <= '1;
      cnt_q   <= '0;
      txd_q   <= 1'b1;
    end else if (xfer) begin
      if (load_gap) begin
        state_q <= SH_GAP;
        cnt_q   <= CNT_W'(GAP_BITS);
        txd_q   <= 1'b1;
      end else begin
        state_q <= SH_FRAME;
        cnt_q   <= mode_abit ? CNT_W'(LEN_AB) : CNT_W'(LEN_NA);
        sh_q    <= {1'b1, (mode_abit ? load_addr : 1'b1), load_data};
        txd_q   <= 1'b0;
      end
    end else if (baud_tick && busy) begin
      if (cnt_q == CNT_W'(1)) begin
        state_q <= SH_IDLE;
        txd_q   <= 1'b1;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (state_q == SH_FRAME) begin
          txd_q <= sh_q[0];
          sh_q  <= {1'b1, sh_q[SH_W-1:1]};
        end
      end
    end
  end

  // R7: the line is held at mark throughout a wake gap
  a_r7_gap_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SH_GAP) |-> txd);
  // R7: gap length never exceeds its configured count
  a_r7_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SH_GAP) |-> (cnt_q <= CNT_W'(GAP_BITS)));
  // R1: an idle engine keeps the line high
  a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SH_IDLE) |-> txd);
  // R3: a data load always begins with a start bit
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !load_gap) |=> !txd);
  // R6: nothing in the engine moves between baud pulses
  a_r6_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> ($stable(state_q) && $stable(txd)));
endmodule

// File: rtl/wake_uart_tx.sv
module wake_uart_tx #(
  parameter int DATA_W   = 8,
  parameter int GAP_BITS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              mode_abit,
  input  logic              irq_en,
  input  logic              wake_set,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_addr_flag,
  output logic              wake_pend,
  output logic              tx_empty,
  output logic              irq,
  output logic              txd
);
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              hold_addr;
  logic              xfer;
  logic              busy;

  wut_hold #(.DATA_W(DATA_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_valid     (s_valid),
    .s_ready     (s_ready),
    .s_data      (s_data),
    .s_addr_flag (s_addr_flag),
    .xfer        (xfer),
    .hold_full   (hold_full),
    .hold_data   (hold_data),
    .hold_addr   (hold_addr)
  );

  wut_wake_ctl u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .wake_set  (wake_set),
    .irq_en    (irq_en),
    .xfer      (xfer),
    .wake_pend (wake_pend),
    .irq       (irq)
  );

  wut_shifter #(.DATA_W(DATA_W), .GAP_BITS(GAP_BITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .mode_abit (mode_abit),
    .load_req  (hold_full),
    .load_gap  (wake_pend),
    .load_data (hold_data),
    .load_addr (hold_addr),
    .xfer      (xfer),
    .busy      (busy),
    .txd       (txd)
  );

  assign tx_empty = !busy && !hold_full;

  // R10: empty status implies the line is at mark and the port is open
  a_r10_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (txd && s_ready));
endmodule

// File: tb/wake_uart_tx_bench.sv
module wake_uart_tx_bench;
  localparam int GAP = 11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       mode_abit = 1'b0;
  logic       irq_en = 1'b1;
  logic       wake_set = 1'b0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_addr_flag = 1'b0;
  logic       s_ready, wake_pend, tx_empty, irq, txd;

  wake_uart_tx u_wake_uart_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .mode_abit(mode_abit),
    .irq_en(irq_en), .wake_set(wake_set), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_addr_flag(s_addr_flag), .wake_pend(wake_pend),
    .tx_empty(tx_empty), .irq(irq), .txd(txd)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int div = 4;
  int tcnt = 0;
  bit done = 0;

  logic [7:0] q_data[$];
  logic       q_abit[$];
  int         q_kind[$];
  bit         last_dummy = 0;

  bit         in_frame = 0;
  int         idle_run = 0;
  int         rx_cnt = 0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_ab = 1'b0;
  logic       prev_ready = 1'b1;
  logic       prev_tick = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  always @(posedge clk) begin
    if (tcnt >= div - 1) begin
      tcnt <= 0;
      baud_tick <= 1'b1;
    end else begin
      tcnt <= tcnt + 1;
      baud_tick <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(0, "watchdog", cyc, 0);
      summary();
      $finish;
    end
  end

  function automatic int bits_after_start(input logic ab_mode);
    return ab_mode ? 10 : 9;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      in_frame = 0; idle_run = 0; prev_ready = 1'b1; prev_tick = 1'b0;
    end else begin
      if (s_ready && !prev_ready) begin
        chk(prev_tick == 1'b1, "R6 ready rise after tick", prev_tick, 1);
        chk(wake_pend == 1'b0, "R8 wake clear at ready rise", wake_pend, 0);
        chk(irq == irq_en, "R9 irq at ready rise", irq, irq_en);
      end
      if (irq) chk(s_ready && !prev_ready, "R9 irq only at transfer", 0, 1);
      if (baud_tick) begin
        if (!in_frame) begin
          if (txd) idle_run++;
          else begin in_frame = 1; rx_cnt = 0; rx_data = 8'h00; end
        end else begin
          if (rx_cnt < 8) rx_data[rx_cnt] = txd;
          else if (mode_abit && rx_cnt == 8) rx_ab = txd;
          if (rx_cnt == bits_after_start(mode_abit) - 1) begin
            chk(txd == 1'b1, "R3 stop bit", txd, 1);
            if (q_data.size() == 0) begin
              chk(0, "R7 unexpected character on line", rx_data, -1);
            end else begin
              logic [7:0] ed;
              logic ea;
              int kd;
              ed = q_data.pop_front();
              ea = q_abit.pop_front();
              kd = q_kind.pop_front();
              chk(rx_data == ed, "R3 data bits", rx_data, ed);
              if (mode_abit) chk(rx_ab == ea, "R4 address bit", rx_ab, ea);
              if (kd == 1) chk(idle_run == 0, "R5 no gap when chained", idle_run, 0);
              if (kd == 2) chk(idle_run == GAP, "R7 exact wake gap", idle_run, GAP);
              if (kd == 3) chk(idle_run >= GAP, "R7 minimum wake gap", idle_run, GAP);
            end
            in_frame = 0;
            idle_run = 0;
          end
          rx_cnt++;
        end
      end
      prev_ready = s_ready;
      prev_tick = baud_tick;
    end
  end

  task automatic send(input logic [7:0] d, input logic a, input bit dummy, input bit early);
    int kind;
    bit busy;
    @(negedge clk); #1;
    if (early) begin
      s_valid = 1'b1; s_data = d; s_addr_flag = a;
      while (!s_ready) begin @(negedge clk); #1; end
      kind = last_dummy ? 3 : 0;
    end else begin
      while (!(s_ready && !baud_tick)) begin @(negedge clk); #1; end
      busy = !tx_empty;
      s_valid = 1'b1; s_data = d; s_addr_flag = a;
      if (last_dummy) kind = busy ? 2 : 3;
      else kind = busy ? 1 : 0;
    end
    if (!dummy) begin
      q_data.push_back(d); q_abit.push_back(a); q_kind.push_back(kind);
    end
    last_dummy = dummy;
    @(negedge clk); #1;
    s_valid = 1'b0;
    s_data = 8'($urandom);
  endtask

  task automatic set_wake();
    @(negedge clk); #1;
    while (!s_ready) begin @(negedge clk); #1; end
    wake_set = 1'b1;
    @(negedge clk); #1;
    wake_set = 1'b0;
    chk(wake_pend == 1'b1, "R8 wake set by pulse", wake_pend, 1);
  endtask

  task automatic drain();
    int n = 0;
    while (!(tx_empty && q_data.size() == 0 && !in_frame) && n < 20000) begin
      @(negedge clk); n++;
    end
    #1;
    chk(tx_empty == 1'b1, "R10 empty after drain", tx_empty, 1);
    chk(txd == 1'b1, "R10 line at mark when empty", txd, 1);
    chk(q_data.size() == 0, "R3 all characters seen", q_data.size(), 0);
    last_dummy = 0;
  endtask

  task automatic random_phase(input logic m, input int d, input int n);
    mode_abit = m;
    div = d;
    for (int i = 0; i < n; i++) begin
      if (($urandom % 5) == 0) begin
        set_wake();
        send(8'($urandom), 1'b0, 1'b1, 1'b0);
      end
      send(8'($urandom), 1'($urandom), 1'b0, ($urandom % 4) == 0);
    end
    drain();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    #1;
    // R1 reset state
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(s_ready == 1'b1, "R1 s_ready", s_ready, 1);
    chk(wake_pend == 1'b0, "R1 wake_pend", wake_pend, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
    rst_n = 1'b1;

    // directed: chained characters, then a wake gap
    send(8'hA5, 1'b0, 1'b0, 1'b0);
    chk(tx_empty == 1'b0, "R10 not empty after write", tx_empty, 0);
    send(8'h3C, 1'b0, 1'b0, 1'b0);
    set_wake();
    send(8'hFF, 1'b0, 1'b1, 1'b0);
    chk(s_ready == 1'b0, "R2 ready low while byte held", s_ready, 0);
    chk(wake_pend == 1'b1, "R8 wake held until transfer", wake_pend, 1);
    send(8'h81, 1'b0, 1'b0, 1'b0);
    send(8'h7E, 1'b0, 1'b0, 1'b0);
    drain();

    // interrupts disabled
    irq_en = 1'b0;
    send(8'h00, 1'b0, 1'b0, 1'b0);
    send(8'hFF, 1'b0, 1'b0, 1'b0);
    drain();
    irq_en = 1'b1;

    // back-pressure: valid held while holding register full (R2)
    send(8'h12, 1'b0, 1'b0, 1'b0);
    send(8'h34, 1'b0, 1'b0, 1'b1);
    send(8'h56, 1'b0, 1'b0, 1'b1);
    drain();

    // address-bit mode, directed flags (R4)
    mode_abit = 1'b1;
    send(8'h5A, 1'b1, 1'b0, 1'b0);
    send(8'hC3, 1'b0, 1'b0, 1'b0);
    drain();

    random_phase(1'b1, 5, 40);
    random_phase(1'b0, 3, 40);
    random_phase(1'b1, 2, 30);

    summary();
    $finish;
  end
endmodule